// File: doc/BRIEF.md
# Power Stage Fault Interrupt and Over-Current Retry Controller

This block gathers fault conditions from an amplifier's power stage and its digital path: over-current, undervoltage, thermal, and a clip condition where a sample is being forced to full scale. Each condition is shown twice.

- A live status bit follows the condition one clock later. Masks do not affect it.
- A sticky bit latches on the rising edge of the condition. It stays set until software issues a read strobe on the register that holds the sticky bits.

Per-source mask bits decide which sticky bits can pull the active-low interrupt pin.

An over-current condition also disables the power outputs at once, putting them in high impedance. If automatic retry is enabled, the outputs are re-enabled after a fixed number of timebase ticks. The default is 85 ticks of a 1 ms timebase. If over-current is still present when the outputs return, they are disabled again on the next clock and the wait starts over. If automatic retry is disabled, the outputs stay off until retry is enabled after the wait has elapsed, or until reset.

Source bit positions are the same on every vector port:

| Bit | Source |
|-----|--------|
| 0 | over-current |
| 1 | undervoltage |
| 2 | thermal |
| 3 | overflow / clip |

Top module: `fault_irq_ctrl`

## Requirements
- R1: While `rstN` is low and after its release, `outEnable` is 1, `stickyFlags` and `liveStatus` are 0 and `irqN` is 1.
- R2: `liveStatus[i]` equals `rawFault[i]` as sampled at the previous clock edge, whatever the value of `irqMask`.
- R3: `stickyFlags[i]` sets at an edge where `rawFault[i]` is 1 and `liveStatus[i]` is 0 (a rising condition). A condition held high does not set the bit again after it has been cleared.
- R4: A clock edge with `readStrobe` at 1 clears every sticky bit that has no new rising condition at that edge.
- R5: If a rising condition and `readStrobe` coincide at one edge, that sticky bit ends up set.
- R6: `irqN` is 0 exactly when some bit `i` has both `stickyFlags[i]` = 1 and `irqMask[i]` = 1. A mask value of 0 keeps that source off the pin.
- R7: If `rawFault[0]` (over-current) is 1 at an edge while `outEnable` is 1, then `outEnable` is 0 after that edge.
- R8: After a trip, the controller counts `tick` pulses. Once RETRY_TICKS pulses have been counted, the next edge with `autoRetryEn` at 1 sets `outEnable` back to 1. With `tick` held at 1, this is the edge RETRY_TICKS+1 edges after the trip.
- R9: If over-current is still 1 when the outputs return, `outEnable` falls again at the following edge and the full wait restarts.
- R10: With `autoRetryEn` at 0, `outEnable` stays 0 indefinitely after a trip. Raising `autoRetryEn` once the wait has elapsed re-enables the outputs at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rawFault | input | NUM_SRC | Raw fault conditions, one bit per source (see the table above) |
| readStrobe | input | 1 | One-cycle pulse when the sticky bits are read; clears them |
| irqMask | input | NUM_SRC | Per-source interrupt enable (1 = unmasked) |
| autoRetryEn | input | 1 | Enables automatic re-enable after an over-current trip |
| tick | input | 1 | Timebase pulse that advances the retry wait |
| outEnable | output | 1 | Power output enable (0 = high impedance) |
| irqN | output | 1 | Interrupt pin, active low |
| stickyFlags | output | NUM_SRC | Latched interrupt bits |
| liveStatus | output | NUM_SRC | Current conditions, one clock behind the raw inputs |

## Verification
The bound checker tests the following properties on every cycle:

- the one-cycle lag of the live bits;
- the persistence of sticky bits when no read occurs;
- the priority of a rising event over a clearing read;
- the immediate trip on over-current;
- re-enable only when retry is enabled.

Some behaviours can be shown only by the bench's scenarios, because they depend on sequences that a per-cycle property cannot express:

- the exact length of the retry wait;
- its restart when over-current persists;
- the late enable of automatic retry;
- the gating of the interrupt pin by the masks, across changes to the masks.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;

  localparam int OC_BIT = 0;

  typedef struct packed {
    logic ocActive;
  } dpStrobes_t;

  typedef enum logic {
    ST_RUN,
    ST_WAIT
  } retryState_t;

endpackage

// File: rtl/fault_irq_datapath.sv
module fault_irq_datapath
  import fault_irq_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] rawFault,
  input  logic               readStrobe,
  input  logic [NUM_SRC-1:0] irqMask,
  output logic [NUM_SRC-1:0] stickyFlags,
  output logic [NUM_SRC-1:0] liveStatus,
  output logic               irqN,
  output dpStrobes_t         strobes
);

  logic [NUM_SRC-1:0] liveQ;
  logic [NUM_SRC-1:0] stickyQ;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic riseNow;
    assign riseNow = rawFault[i] & ~liveQ[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        liveQ[i]   <= 1'b0;
        stickyQ[i] <= 1'b0;
      end else begin
        liveQ[i] <= rawFault[i];
        if (riseNow)
          stickyQ[i] <= 1'b1;
        else if (readStrobe)
          stickyQ[i] <= 1'b0;
      end
    end
  end

  assign stickyFlags      = stickyQ;
  assign liveStatus       = liveQ;
  assign irqN             = ~|(stickyQ & irqMask);
  assign strobes.ocActive = rawFault[OC_BIT];

endmodule

// File: rtl/fault_irq_retry.sv
module fault_irq_retry
  import fault_irq_pkg::*;
#(
  parameter int RETRY_TICKS = 85
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobes_t strobes,
  input  logic       autoRetryEn,
  input  logic       tick,
  output logic       outEnable
);

  localparam int CNT_W = $clog2(RETRY_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(RETRY_TICKS);

  retryState_t       state;
  logic [CNT_W-1:0]  waitCnt;
  logic              oeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      waitCnt <= '0;
      oeQ     <= 1'b1;
    end else begin
      case (state)
        ST_RUN: begin
          if (strobes.ocActive) begin
            state   <= ST_WAIT;
            waitCnt <= '0;
            oeQ     <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (waitCnt == CNT_DONE) begin
            if (autoRetryEn) begin
              state <= ST_RUN;
              oeQ   <= 1'b1;
            end
          end else if (tick) begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: begin
          state <= ST_RUN;
          oeQ   <= 1'b1;
        end
      endcase
    end
  end

  assign outEnable = oeQ;

endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fault_irq_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int RETRY_TICKS = 85
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] rawFault,
  input  logic               readStrobe,
  input  logic [NUM_SRC-1:0] irqMask,
  input  logic               autoRetryEn,
  input  logic               tick,
  output logic               outEnable,
  output logic               irqN,
  output logic [NUM_SRC-1:0] stickyFlags,
  output logic [NUM_SRC-1:0] liveStatus
);

  dpStrobes_t strobes;

  fault_irq_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .rawFault    (rawFault),
    .readStrobe  (readStrobe),
    .irqMask     (irqMask),
    .stickyFlags (stickyFlags),
    .liveStatus  (liveStatus),
    .irqN        (irqN),
    .strobes     (strobes)
  );

  fault_irq_retry #(.RETRY_TICKS(RETRY_TICKS)) u_retry (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .autoRetryEn (autoRetryEn),
    .tick        (tick),
    .outEnable   (outEnable)
  );

endmodule

// File: rtl/fault_irq_ctrl_chk.sv
module fault_irq_ctrl_chk #(
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] rawFault,
  input logic               readStrobe,
  input logic               autoRetryEn,
  input logic               outEnable,
  input logic [NUM_SRC-1:0] stickyFlags,
  input logic [NUM_SRC-1:0] liveStatus
);

  // R2
  live_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (liveStatus == $past(rawFault)));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readStrobe |=> ((stickyFlags & $past(stickyFlags)) == $past(stickyFlags)));

  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rawFault & ~liveStatus) != '0) |=>
      ((stickyFlags & $past(rawFault & ~liveStatus)) == $past(rawFault & ~liveStatus)));

  // R7
  oc_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rawFault[0] && outEnable) |=> !outEnable);

  // R10
  retry_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEnable) |-> $past(autoRetryEn));

endmodule

bind fault_irq_ctrl fault_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/fault_irq_ctrl_bench.sv
module fault_irq_ctrl_bench;

  localparam int NSRC  = 4;
  localparam int RTICK = 85;

  typedef struct {
    string     tag;
    logic [3:0] sticky;
    logic [3:0] live;
    logic      irqN;
    logic      oe;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] rawFault = '0;
  logic       readStrobe = 1'b0;
  logic [3:0] irqMask = '0;
  logic       autoRetryEn = 1'b0;
  logic       tick = 1'b1;
  logic       outEnable;
  logic       irqN;
  logic [3:0] stickyFlags;
  logic [3:0] liveStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  expItem_t expQ[$];
  logic [3:0] mSticky = '0;
  logic [3:0] mLive = '0;

  always #2 clk = ~clk;

  fault_irq_ctrl #(.NUM_SRC(NSRC), .RETRY_TICKS(RTICK)) u_fault_irq_ctrl (
    .clk(clk), .rstN(rstN), .rawFault(rawFault), .readStrobe(readStrobe),
    .irqMask(irqMask), .autoRetryEn(autoRetryEn), .tick(tick),
    .outEnable(outEnable), .irqN(irqN), .stickyFlags(stickyFlags),
    .liveStatus(liveStatus)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic compare(input expItem_t e);
    checks++;
    if (stickyFlags !== e.sticky || liveStatus !== e.live ||
        irqN !== e.irqN || outEnable !== e.oe) begin
      errors++;
      $display("FAIL %s: actual sticky=%b live=%b irqN=%b oe=%b expected sticky=%b live=%b irqN=%b oe=%b",
               e.tag, stickyFlags, liveStatus, irqN, outEnable,
               e.sticky, e.live, e.irqN, e.oe);
    end
  endtask

  task automatic step(input logic [3:0] raw, input logic rd, input logic [3:0] msk,
                      input logic are, input logic expOe, input string tag);
    expItem_t e;
    @(negedge clk);
    rawFault    = raw;
    readStrobe  = rd;
    irqMask     = msk;
    autoRetryEn = are;
    mSticky  = (mSticky & ~{4{rd}}) | (raw & ~mLive);
    mLive    = raw;
    e.tag    = tag;
    e.sticky = mSticky;
    e.live   = mLive;
    e.irqN   = ~|(mSticky & msk);
    e.oe     = expOe;
    expQ.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    expItem_t r;
    repeat (3) @(posedge clk);
    #1;
    r.tag = "R1 reset state"; r.sticky = '0; r.live = '0; r.irqN = 1'b1; r.oe = 1'b1;
    compare(r);
    @(negedge clk);
    rstN = 1'b1;

    step(4'b0000, 0, 4'b1111, 1, 1, "R1 idle after release");
    step(4'b0010, 0, 4'b1111, 1, 1, "R3 R6 uv rise");
    step(4'b0010, 1, 4'b1111, 1, 1, "R4 read clears");
    step(4'b0010, 0, 4'b1111, 1, 1, "R3 held no relatch");
    step(4'b0110, 0, 4'b1011, 1, 1, "R6 R2 masked thermal");
    step(4'b0110, 0, 4'b1111, 1, 1, "R6 unmasked thermal");
    step(4'b1000, 1, 4'b1111, 1, 1, "R5 overflow with read");
    step(4'b0000, 1, 4'b1111, 1, 1, "R4 clear all");

    // over-current trip and timed retry
    step(4'b0001, 0, 4'b1111, 1, 0, "R7 oc trips");
    for (int k = 0; k < RTICK; k++) step(4'b0000, 0, 4'b1111, 1, 0, "R8 waiting");
    step(4'b0000, 0, 4'b1111, 1, 1, "R8 retry engages");
    step(4'b0000, 1, 4'b1111, 1, 1, "R4 clear oc");

    // persistent over-current
    step(4'b0001, 0, 4'b1111, 1, 0, "R7 oc trips again");
    for (int k = 0; k < RTICK; k++) step(4'b0001, 0, 4'b1111, 1, 0, "R9 waiting");
    step(4'b0001, 0, 4'b1111, 1, 1, "R9 retry one cycle");
    step(4'b0001, 0, 4'b1111, 1, 0, "R9 retrip");
    for (int k = 0; k < RTICK; k++) step(4'b0000, 0, 4'b1111, 1, 0, "R9 timer restarted");
    step(4'b0000, 0, 4'b1111, 1, 1, "R9 retry after restart");
    step(4'b0000, 1, 4'b1111, 1, 1, "R4 clear");

    // retry disabled
    step(4'b0001, 0, 4'b1111, 0, 0, "R10 trip no retry");
    for (int k = 0; k < RTICK + 15; k++) step(4'b0000, 0, 4'b1111, 0, 0, "R10 stays off");
    step(4'b0000, 0, 4'b1111, 1, 1, "R10 late enable");
    step(4'b0000, 1, 4'b0000, 1, 1, "R6 masked clear");

    repeat (3) @(posedge clk);
    done = 1'b1;
    summary();
  end

endmodule